// File: doc/BRIEF.md
# Self-correcting Johnson timing generator

This block produces a repeating train of eight non-overlapping timing phases from four flip-flops. The flip-flops form a switch-tail ring: the inverted output of the last stage feeds the first stage, so four stages step through eight distinct patterns. One two-input AND term per phase turns each pattern into a single active phase line. Sequencing logic elsewhere in the chip can then gate its operations on those lines.

A plain switch-tail ring that lands on an unused pattern never finds its way back. Such a pattern can come from an upset or from a bad preset. Here the input of the third stage is not a plain copy of the second stage. It is the AND of the second stage with the OR of the first and third stages. As a result, every unused pattern drains into the legal cycle within a few advancing clocks.

Software cannot reach the block. An enable input paces the ring. A preset port lets the surrounding logic seed any pattern, and the correction path is exercised through it. The stage count is a parameter. The decode pattern extends to any width, but the correction and the recovery bound are defined for four stages.

Top module: `johnson_timing_gen`

## Requirements
- R1: Driving `rst_n` low clears every stage to 0 at once, without waiting for a clock edge. While reset holds, `phase_o` equals 8'h01, so only phase 0 is high.
- R2: Bit i of `state_o` is stage i. Stage 0 is the first stage, fed from the inverted last stage. With `adv` high, the legal patterns advance one per clock in this order, written as stages 0,1,2,3: 0000, 1000, 1100, 1110, 1111, 0111, 0011, 0001, then back to 0000.
- R3: In each legal pattern exactly one phase line is high: phase k for the k-th pattern of the R2 order, counting from 0.
- R4: Each phase line is a 2-input AND of stage bits, in every pattern, legal or not. Writing stages 0..3 as a, b, c, d, the lines are: phase0 = a'd', phase1 = ab', phase2 = bc', phase3 = cd', phase4 = ad, phase5 = a'b, phase6 = b'c, phase7 = c'd.
- R5: With `adv` and `seed_we` both low, the pattern and every phase line hold unchanged across clock edges.
- R6: On an advancing edge, stage 0 takes the inverse of stage 3, stage 1 takes stage 0, and stage 3 takes stage 2. Stage 2 takes (stage0 OR stage2) AND stage1.
- R7: From any of the eight unused patterns, the ring is in a legal pattern after at most five advancing clocks.
- R8: With `seed_we` high, the next edge copies `seed_val` into the stages, whatever the value of `adv`.
- R9: Reset is released through a two-stage synchronizer. After `rst_n` rises, the first two edges leave the ring at 0000 even with `adv` high. The third edge is the first one that advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv | input | 1 | Advance enable: the ring steps on each edge while high |
| seed_we | input | 1 | Preset strobe; takes priority over `adv` |
| seed_val | input | 4 | Pattern to preset, bit i to stage i |
| state_o | output | 4 | Raw stage pattern, bit i is stage i |
| phase_o | output | 8 | Timing phase lines, bit k is phase k |

## Verification
An internal pattern that is wrong shows up on `phase_o` in the same cycle it is entered, because the decode is combinational on the stage flops. The symptom is two lines high, no line high, or a line out of turn. The bench seeds all sixteen patterns and compares every clock against its own model of the ring. A broken correction term therefore appears as a pattern mismatch on the first advancing edge. A ring that never recovers also trips the five-clock recovery check. A slip in the reset synchronizer shows up as the first advance arriving one edge early or late.

// File: rtl/johnson_pkg.sv
package johnson_pkg;

  // Operation selected for the stage flops on each edge.
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_STEP = 2'd1,
    OP_LOAD = 2'd2
  } ring_op_e;

  // Stage whose input carries the correction term.
  localparam int FIX_STAGE = 2;

  // Advancing clocks needed to leave the worst unused 4-stage pattern.
  localparam int RECOVER_MAX = 5;

endpackage

// File: rtl/johnson_rst_sync.sv
module johnson_rst_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [DEPTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[DEPTH-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[DEPTH-1];

endmodule

// File: rtl/johnson_stage_core.sv
module johnson_stage_core
  import johnson_pkg::*;
#(
  parameter int STAGES  = 4,
  parameter bit CORRECT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_en,
  input  logic              load_en,
  input  logic [STAGES-1:0] load_val,
  output logic [STAGES-1:0] stage_q
);

  ring_op_e          op;
  logic [STAGES-1:0] shift_v;
  logic [STAGES-1:0] stage_d;

  // Switch-tail feedback into the first stage.
  assign shift_v[0] = ~stage_q[STAGES-1];

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    if (CORRECT && (i == FIX_STAGE)) begin : g_fix
      // The OR of the neighbours gates the copy of the previous stage.
      assign shift_v[i] = (stage_q[i-2] | stage_q[i]) & stage_q[i-1];
    end else begin : g_copy
      assign shift_v[i] = stage_q[i-1];
    end
  end

  always_comb begin
    if (load_en)     op = OP_LOAD;
    else if (adv_en) op = OP_STEP;
    else             op = OP_HOLD;
  end

  always_comb begin
    case (op)
      OP_LOAD: stage_d = load_val;
      OP_STEP: stage_d = shift_v;
      default: stage_d = stage_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              stage_q <= '0;
    else if (op != OP_HOLD)  stage_q <= stage_d;
  end

endmodule

// File: rtl/johnson_phase_decode.sv
module johnson_phase_decode #(
  parameter int STAGES = 4,
  localparam int PHASES = 2 * STAGES
) (
  input  logic [STAGES-1:0] stage_q,
  output logic [PHASES-1:0] phase
);

  // First and last stage both low / both high.
  assign phase[0]      = ~stage_q[0] & ~stage_q[STAGES-1];
  assign phase[STAGES] =  stage_q[0] &  stage_q[STAGES-1];

  for (genvar i = 1; i < STAGES; i++) begin : g_edge
    // A one front and a zero front between neighbours.
    assign phase[i]        =  stage_q[i-1] & ~stage_q[i];
    assign phase[STAGES+i] = ~stage_q[i-1] &  stage_q[i];
  end

endmodule

// File: rtl/johnson_timing_gen.sv
module johnson_timing_gen #(
  parameter int STAGES     = 4,
  parameter int SYNC_DEPTH = 2,
  localparam int PHASES    = 2 * STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              seed_we,
  input  logic [STAGES-1:0] seed_val,
  output logic [STAGES-1:0] state_o,
  output logic [PHASES-1:0] phase_o
);

  logic              core_rst_n;
  logic [STAGES-1:0] stage_q;

  johnson_rst_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (core_rst_n)
  );

  johnson_stage_core #(.STAGES(STAGES), .CORRECT(1'b1)) u_core (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .adv_en   (adv),
    .load_en  (seed_we),
    .load_val (seed_val),
    .stage_q  (stage_q)
  );

  johnson_phase_decode #(.STAGES(STAGES)) u_dec (
    .stage_q (stage_q),
    .phase   (phase_o)
  );

  assign state_o = stage_q;

endmodule

// File: rtl/johnson_timing_chk.sv
module johnson_timing_chk
  import johnson_pkg::*;
#(
  parameter int STAGES = 4,
  localparam int PHASES = 2 * STAGES
) (
  input logic              clk,
  input logic              rst_n,
  input logic              adv,
  input logic              seed_we,
  input logic [STAGES-1:0] seed_val,
  input logic [STAGES-1:0] state,
  input logic [PHASES-1:0] phase
);

  function automatic logic legal(input logic [STAGES-1:0] s);
    int fronts = 0;
    for (int i = 0; i < STAGES - 1; i++)
      if (s[i] != s[i+1]) fronts++;
    return fronts <= 1;
  endfunction

  AST_PHASE_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    legal(state) |-> $countones(phase) == 1); // R3

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !seed_we) |=> $stable(state)); // R5

  AST_SEED_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    seed_we |=> state == $past(seed_val)); // R8

  AST_LEGAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !seed_we && legal(state)) |=>
      state == {$past(state[STAGES-2:0]), ~$past(state[STAGES-1])}); // R2

  if (STAGES == 4) begin : g_recover
    logic [3:0] bad_run;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         bad_run <= '0;
      else if (seed_we || legal(state))   bad_run <= '0;
      else if (adv && bad_run != 4'hF)    bad_run <= bad_run + 4'd1;
    end

    AST_RECOVER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      bad_run <= 4'(RECOVER_MAX)); // R7
  end

endmodule

bind johnson_timing_gen johnson_timing_chk #(.STAGES(STAGES)) u_chk (
  .clk      (clk),
  .rst_n    (core_rst_n),
  .adv      (adv),
  .seed_we  (seed_we),
  .seed_val (seed_val),
  .state    (state_o),
  .phase    (phase_o)
);

// File: tb/sim_johnson_timing_gen.sv
`timescale 1ns/1ps
module sim_johnson_timing_gen;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         adv;
  logic         seed_we;
  logic [W-1:0] seed_val;
  logic [W-1:0] state_o;
  logic [7:0]   phase_o;

  always #2 clk = ~clk; // 250 MHz

  johnson_timing_gen #(.STAGES(W)) u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .seed_we  (seed_we),
    .seed_val (seed_val),
    .state_o  (state_o),
    .phase_o  (phase_o)
  );

  typedef struct {
    logic [W-1:0] st;
    string        tag;
  } exp_t;

  exp_t   sb_q[$];
  exp_t   cur;
  int     n_vec = 0;
  int     n_bad = 0;
  logic [W-1:0] m_st;
  int     m_block;

  // Ring model from R6; bit i = stage i.
  function automatic logic [W-1:0] ring_next(input logic [W-1:0] s);
    logic [W-1:0] n;
    n[0] = ~s[3];
    n[1] = s[0];
    n[2] = (s[0] | s[2]) & s[1];
    n[3] = s[2];
    return n;
  endfunction

  // Decode terms from R4: a=s[0], b=s[1], c=s[2], d=s[3].
  function automatic logic [7:0] ring_dec(input logic [W-1:0] s);
    logic [7:0] p;
    p[0] = ~s[0] & ~s[3];
    p[1] =  s[0] & ~s[1];
    p[2] =  s[1] & ~s[2];
    p[3] =  s[2] & ~s[3];
    p[4] =  s[0] &  s[3];
    p[5] = ~s[0] &  s[1];
    p[6] = ~s[1] &  s[2];
    p[7] = ~s[2] &  s[3];
    return p;
  endfunction

  // Legal patterns of R2, written with bit i = stage i.
  function automatic bit ring_legal(input logic [W-1:0] s);
    return s inside {4'b0000, 4'b0001, 4'b0011, 4'b0111,
                     4'b1111, 4'b1110, 4'b1100, 4'b1000};
  endfunction

  task automatic chk(input bit good, input string req,
                     input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: sets inputs for the coming edge and queues the expected result.
  task automatic step(input bit a, input bit w, input logic [W-1:0] v,
                      input string tag);
    exp_t e;
    @(negedge clk);
    adv      = a;
    seed_we  = w;
    seed_val = v;
    if (m_block > 0) m_block--;
    else if (w)      m_st = v;
    else if (a)      m_st = ring_next(m_st);
    e.st  = m_st;
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Monitor: compares each edge's result with the queued expectation.
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      cur = sb_q.pop_front();
      chk(state_o === cur.st, cur.tag, {4'h0, state_o}, {4'h0, cur.st});
      chk(phase_o === ring_dec(cur.st), "R4", phase_o, ring_dec(cur.st));
      if (ring_legal(cur.st))
        chk($countones(phase_o) == 1, "R3", phase_o, ring_dec(cur.st));
    end
  end

  // Releases reset at a falling edge; the synchronizer holds two edges (R9).
  task automatic release_reset();
    exp_t e;
    @(negedge clk);
    rst_n    = 1'b1;
    adv      = 1'b1;
    seed_we  = 1'b0;
    m_st     = '0;
    m_block  = 1;
    e.st  = '0;
    e.tag = "R9";
    sb_q.push_back(e);
    step(1'b1, 1'b0, '0, "R9");
    step(1'b1, 1'b0, '0, "R9");
  endtask

  initial begin
    rst_n    = 1'b0;
    adv      = 1'b0;
    seed_we  = 1'b0;
    seed_val = '0;
    m_st     = '0;
    m_block  = 0;
    #11;
    chk(state_o === 4'b0000, "R1", {4'h0, state_o}, 8'h00);
    chk(phase_o === 8'h01,   "R1", phase_o, 8'h01);

    release_reset();
    for (int i = 0; i < 18; i++) step(1'b1, 1'b0, '0, "R2");

    // Idle in the middle of the cycle.
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 4'b1010, "R5");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, '0, "R2");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, '0, "R5");

    // Preset wins over advance.
    step(1'b1, 1'b1, 4'b0111, "R8");
    step(1'b1, 1'b0, '0, "R2");

    // Every pattern as a seed, then five advances.
    for (int c = 0; c < 16; c++) begin
      step(1'b0, 1'b1, 4'(c), "R8");
      for (int k = 0; k < 5; k++)
        step(1'b1, 1'b0, '0, ring_legal(4'(c)) ? "R2" : "R6");
      @(posedge clk);
      #2;
      chk(ring_legal(state_o), "R7", {4'h0, state_o}, {4'h0, state_o});
    end

    // Unused pattern held while idle.
    step(1'b0, 1'b1, 4'b0110, "R8");
    step(1'b0, 1'b0, '0, "R5");
    step(1'b0, 1'b0, '0, "R5");

    // Asynchronous reset between edges.
    step(1'b1, 1'b0, '0, "R6");
    @(negedge clk);
    adv     = 1'b0;
    seed_we = 1'b0;
    @(posedge clk);
    #2;
    rst_n = 1'b0;
    #0.5;
    chk(state_o === 4'b0000, "R1", {4'h0, state_o}, 8'h00);
    chk(phase_o === 8'h01,   "R1", phase_o, 8'h01);
    release_reset();
    for (int i = 0; i < 9; i++) step(1'b1, 1'b0, '0, "R2");

    @(posedge clk);
    #3;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule